// File: doc/BRIEF.md
# Counted Block Transfer Engine

This engine carries out a block-move instruction. The processor hands it a starting source address, a destination and an element count, then gives a single start strobe. From then on the engine reads one element per clock from a synchronous memory pool, and writes each element one clock later. Each element goes either to a memory write port at a destination address that advances, or to a fixed output port, so a buffer can be streamed to pins, for example as pixel data.

While a run is in progress the engine holds the fetch-halt output high, so every memory cycle goes to the transfer. A counter register holds the number of elements still to be written. It steps down once per write, and the run ends when it reaches zero. A one-cycle done pulse marks the end of the run. A start with a count of zero finishes at once.

Top module: `blkmove_engine`

## Requirements
- R1: While reset is asserted, and in the cycles after reset before any start, busy_o, fetch_halt_o, done_o, rd_en_o, wr_en_o and port_en_o are all low.
- R2: A start with count N > 0, sampled at a clock edge, makes busy_o and fetch_halt_o high for exactly N+1 cycles, beginning in the cycle after that edge. fetch_halt_o equals busy_o in every cycle.
- R3: During a run, rd_en_o is high in exactly N cycles, which are the first N busy cycles. rd_addr_o is the start source address in the first of these cycles and rises by one in each following read.
- R4: When dst_is_port_i = 0 (destination memory), write k of the run (k counted from 0) has wr_en_o high one cycle after read k. It sets wr_addr_o = destination + k and wr_data_o = the data returned for read k.
- R5: When dst_is_port_i = 1 (destination port), each element appears on port_data_o with port_en_o high, one cycle after its read. wr_en_o stays low for the whole run. wr_en_o and port_en_o are never high together.
- R6: A start with count 0 raises no rd_en_o, wr_en_o or port_en_o and leaves busy_o low. done_o is high for one cycle, in the cycle after the start edge.
- R7: For a run with N > 0, done_o is high in exactly one cycle: the final busy cycle, which carries the last write. done_o is low in the cycle after it.
- R8: A start that arrives while busy_o is high is ignored. The run in progress keeps its length, its addresses and its data, and no second run follows it.
- R9: The number of write or port strobes in a run equals the loaded count N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, one cycle |
| src_addr_i | input | AW | First source address |
| dst_addr_i | input | AW | First destination address (used for memory destination) |
| count_i | input | CW | Number of elements to move |
| dst_is_port_i | input | 1 | 1 = output port destination, 0 = memory destination |
| rd_en_o | output | 1 | Source read request |
| rd_addr_o | output | AW | Source read address |
| rd_data_i | input | DW | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW | Memory write address |
| wr_data_o | output | DW | Memory write data |
| port_en_o | output | 1 | Output port strobe |
| port_data_o | output | DW | Output port data |
| busy_o | output | 1 | Run in progress |
| fetch_halt_o | output | 1 | Halts instruction fetch while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with AW = 8, DW = 16 and CW = 5. With an 8-bit address, a 256-entry model memory covers the whole address space. With a 5-bit count, the largest possible run of 31 elements can be tested directly, next to the corner runs of 0 and 1 elements. Memory-to-memory copies are written back into the model, and later port streams read them again, so destination stepping is confirmed through the port data.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic {
    DST_MEM  = 1'b0,
    DST_PORT = 1'b1
  } dst_kind_e;
endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  output logic          launch_o,
  output logic          busy_o,
  output logic          rd_en_o,
  output logic          wr_fire_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          busy_q, busy_d;
  logic [CW-1:0] rd_left_q, rd_left_d;
  logic [CW-1:0] wr_left_q, wr_left_d;
  logic          pend_q, pend_d;
  logic          zdone_q, zdone_d;
  logic          idle_start, zero_hit, last_wr;

  // next-state logic
  always_comb begin
    idle_start = start_i && !busy_q;
    launch_o   = idle_start && (count_i != '0);
    zero_hit   = idle_start && (count_i == '0);
    rd_en_o    = busy_q && (rd_left_q != '0);
    last_wr    = pend_q && (wr_left_q == ONE);

    busy_d = busy_q;
    if (launch_o)     busy_d = 1'b1;
    else if (last_wr) busy_d = 1'b0;

    rd_left_d = rd_left_q;
    if (launch_o)     rd_left_d = count_i;
    else if (rd_en_o) rd_left_d = rd_left_q - ONE;

    wr_left_d = wr_left_q;
    if (launch_o)    wr_left_d = count_i;
    else if (pend_q) wr_left_d = wr_left_q - ONE;

    pend_d  = rd_en_o;
    zdone_d = zero_hit;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rd_left_q <= '0;
      wr_left_q <= '0;
      pend_q    <= 1'b0;
      zdone_q   <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      rd_left_q <= rd_left_d;
      wr_left_q <= wr_left_d;
      pend_q    <= pend_d;
      zdone_q   <= zdone_d;
    end
  end

  assign busy_o    = busy_q;
  assign wr_fire_o = pend_q;
  assign done_o    = last_wr || zdone_q;
endmodule

// File: rtl/blkmove_agen.sv
module blkmove_agen
  import blkmove_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  dst_kind_e     kind_i,
  input  logic          rd_step_i,
  input  logic          wr_step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output dst_kind_e     kind_o
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  dst_kind_e     kind_q, kind_d;
  logic          src_en, dst_en, kind_en;

  // next-state logic with explicit enables
  always_comb begin
    src_en  = launch_i || rd_step_i;
    dst_en  = launch_i || (wr_step_i && kind_q == DST_MEM);
    kind_en = launch_i;
    src_d   = launch_i ? src_i  : src_q + STEP;
    dst_d   = launch_i ? dst_i  : dst_q + STEP;
    kind_d  = kind_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      kind_q <= DST_MEM;
    end else begin
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (kind_en) kind_q <= kind_d;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign kind_o = kind_q;
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          dst_is_port_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          port_en_o,
  output logic [DW-1:0] port_data_o,
  output logic          busy_o,
  output logic          fetch_halt_o,
  output logic          done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       launch, wr_fire;
  dst_kind_e  kind;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  blkmove_ctrl #(.CW(CW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .count_i   (count_i),
    .launch_o  (launch),
    .busy_o    (busy_o),
    .rd_en_o   (rd_en_o),
    .wr_fire_o (wr_fire),
    .done_o    (done_o)
  );

  blkmove_agen #(.AW(AW)) agen_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch_i  (launch),
    .src_i     (src_addr_i),
    .dst_i     (dst_addr_i),
    .kind_i    (dst_is_port_i ? DST_PORT : DST_MEM),
    .rd_step_i (rd_en_o),
    .wr_step_i (wr_fire),
    .src_o     (rd_addr_o),
    .dst_o     (wr_addr_o),
    .kind_o    (kind)
  );

  assign wr_en_o      = wr_fire && (kind == DST_MEM);
  assign port_en_o    = wr_fire && (kind == DST_PORT);
  assign wr_data_o    = rd_data_i;
  assign port_data_o  = rd_data_i;
  assign fetch_halt_o = busy_o;
endmodule

// File: rtl/blkmove_chk.sv
module blkmove_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_en_o,
  input logic          port_en_o,
  input logic          busy_o,
  input logic          done_o
);
  AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o); // R3

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + AW'(1))); // R3

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o || port_en_o) |-> $past(rd_en_o)); // R4

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, port_en_o})); // R5

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && busy_o) |=> !busy_o); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> busy_o); // R8
endmodule

bind blkmove_engine blkmove_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .wr_en_o   (wr_en_o),
  .port_en_o (port_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/blkmove_engine_tb_top.sv
module blkmove_engine_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0;
  logic [AW-1:0] dst_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          dst_is_port_i = 1'b0;
  logic          rd_en_o, wr_en_o, port_en_o, busy_o, fetch_halt_o, done_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [DW-1:0] rd_data_i, wr_data_o, port_data_o;

  logic [DW-1:0] mem [256];

  typedef struct packed {
    logic          is_port;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;
  exp_t sb[$];

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  blkmove_engine #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .count_i(count_i),
    .dst_is_port_i(dst_is_port_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .port_en_o(port_en_o), .port_data_o(port_data_o),
    .busy_o(busy_o), .fetch_halt_o(fetch_halt_o), .done_o(done_o)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (rd_en_o) rd_data_i <= mem[rd_addr_o];
    if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n && (wr_en_o || port_en_o)) begin
      total++;
      if (wr_en_o && port_en_o) begin
        bad++;
        $display("FAIL R5 act=both_strobes exp=one");
      end else if (sb.size() == 0) begin
        bad++;
        $display("FAIL R9 act=extra_strobe exp=none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_port) begin
          if (!port_en_o || port_data_o != e.data) begin
            bad++;
            $display("FAIL R5 act=%0h/%0d exp=%0h/1", port_data_o, port_en_o, e.data);
          end
        end else begin
          if (!wr_en_o || wr_addr_o != e.addr || wr_data_o != e.data) begin
            bad++;
            $display("FAIL R4 act=%0h@%0h exp=%0h@%0h", wr_data_o, wr_addr_o, e.data, e.addr);
          end
        end
      end
    end
  end

  task automatic run_xfer(input int src, input int dst, input int cnt,
                          input bit to_port, input bit inject);
    int busy_n, rd_n, done_n, guard;
    bit last_done;
    for (int k = 0; k < cnt; k++) begin
      exp_t e;
      e.is_port = to_port;
      e.addr    = AW'(dst + k);
      e.data    = mem[AW'(src + k)];
      sb.push_back(e);
    end
    @(negedge clk);
    src_addr_i = AW'(src); dst_addr_i = AW'(dst);
    count_i = CW'(cnt); dst_is_port_i = to_port; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (cnt == 0) begin
      chk(!busy_o, "R6 busy", busy_o, 0);
      chk(done_o, "R6 done", done_o, 1);
      chk(!rd_en_o && !wr_en_o && !port_en_o, "R6 strobes", rd_en_o, 0);
      @(negedge clk);
      chk(!done_o, "R6 done width", done_o, 0);
      chk(!busy_o, "R6 busy after", busy_o, 0);
      return;
    end
    busy_n = 0; rd_n = 0; done_n = 0; guard = 0; last_done = 0;
    while (busy_o && guard < 200) begin
      guard++;
      busy_n++;
      if (fetch_halt_o != busy_o) chk(0, "R2 halt", fetch_halt_o, busy_o);
      if (rd_en_o) begin
        if (rd_addr_o != AW'(src + rd_n)) chk(0, "R3 rd_addr", rd_addr_o, src + rd_n);
        rd_n++;
      end
      if (done_o) done_n++;
      last_done = done_o;
      start_i = 1'b0;
      if (inject && busy_n == 2) begin
        src_addr_i = 8'hF0; dst_addr_i = 8'h00; count_i = 5'd3; start_i = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(busy_n == cnt + 1, inject ? "R8 length" : "R2 length", busy_n, cnt + 1);
    chk(rd_n == cnt, "R3 reads", rd_n, cnt);
    chk(done_n == 1 && last_done, "R7 done", done_n, 1);
    chk(!done_o, "R7 done low", done_o, 0);
    chk(sb.size() == 0, "R9 strobes", sb.size(), 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !rd_en_o, "R8 no second run", busy_o, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !rd_en_o, "R1 in reset", busy_o, 0);
    chk(!wr_en_o && !port_en_o && !fetch_halt_o, "R1 strobes", wr_en_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !fetch_halt_o, "R1 after reset", busy_o, 0);
    run_xfer(8'h10, 8'h80, 5, 1'b0, 1'b0);   // R4 memory copy
    run_xfer(8'h80, 8'h00, 5, 1'b1, 1'b0);   // R5 stream the copy
    run_xfer(8'h33, 8'h90, 1, 1'b0, 1'b0);   // single element
    run_xfer(8'h90, 8'h00, 1, 1'b1, 1'b0);
    run_xfer(8'h20, 8'h00, 0, 1'b0, 1'b0);   // R6 zero count
    run_xfer(8'h20, 8'h00, 31, 1'b1, 1'b0);  // maximum count
    run_xfer(8'h40, 8'hC0, 6, 1'b0, 1'b1);   // R8 start during run
    run_xfer(8'hC0, 8'h00, 6, 1'b1, 1'b0);   // verify copied region
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule